// File: doc/BRIEF.md
# Serial Clock Rate Generator

This block derives the timing for a serial clock from the base clock it runs on. It holds a single 32-bit control word written and read through a strobe interface. When enabled, it emits a one-cycle `sck_tick` pulse once every half-period. It also drives a reference `sck_out` level that inverts on each pulse. A serial engine uses the pulses to decide when to flip its own clock line and when to shift data. The resulting serial clock runs at the base frequency divided by twice the effective divider.

Software changes the rate by writing a new divider value. A write that alters the divider drops a read-only ready flag. The new value does not take effect at once: it waits for the next half-period boundary, so no shortened phase ever appears on the clock. The flag comes back only after the new rate has produced two full half-periods. Software polls the flag before starting a transfer at the new speed. When the generator is switched off, a new divider takes effect immediately.

Top module: `sck_rate_gen`

## Requirements
- R1: After reset, the control word reads 0x0000_0002. That is: enable 0, ready flag 1, divider 0. `sck_tick` and `sck_out` are both 0.
- R2: The control word has the enable at bit 0, the read-only ready flag at bit 1, and the divider at bits 15:8. All other bits read 0 and ignore writes. A read strobe returns the state as it stood before that clock edge, one cycle later on `cfg_rdata`.
- R3: One cycle after the enable bit is seen low, `sck_tick` stays 0 and `sck_out` stays 0.
- R4: With effective divider d and the enable set, `sck_tick` pulses for one cycle every d cycles. The first pulse comes d cycles after the enable takes effect. `sck_out` inverts on each pulse and holds between pulses.
- R5: A divider value of 0 behaves as 1, giving a pulse on every cycle.
- R6: A write whose divider field differs from the held divider clears the ready flag at that edge. A write with an unchanged divider leaves the flag untouched.
- R7: While running, a new divider takes effect only at the next pulse of the old rate. That pulse keeps the old spacing, and later pulses use the new spacing.
- R8: While running, the ready flag returns at the same edge as the second pulse after the new divider took effect. The worst case is therefore the old divider plus twice the new divider cycles after the write.
- R9: A divider written while disabled takes effect at the write edge. If the same write also sets the enable, the flag returns with the second pulse. If the generator is disabled, or is switched off while waiting, the flag returns on the next edge.
- R10: Writes to bit 1 have no effect on the ready flag, whether they carry 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_rd | input | 1 | Read strobe for the control word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| sck_tick | output | 1 | One-cycle pulse at each serial clock half-period |
| sck_out | output | 1 | Reference serial clock level, low while idle |

## Verification
The hardest case to reach is a rate change whose boundary and settle windows overlap other events. One case is a divider write that lands between two pulses of a slow old rate. Another is a write whose settle is cut short by switching the generator off. The stimulus times each write to an exact edge, counted from a free-running cycle counter. It places one change mid-period and disables another one cycle after its write. For every scenario, the bench computes ahead of time the exact cycle of each expected pulse. With the read strobe held high, it samples the ready flag on the exact cycles before and after it should rise.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;

    localparam int REG_W   = 32;
    localparam int DIV_W   = 8;
    localparam int EN_BIT  = 0;
    localparam int RDY_BIT = 1;
    localparam int DIV_LSB = 8;
    localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [REG_W-1:0] word_t;

    typedef struct packed {
        logic en;
        div_t div;
    } ctl_t;

    typedef enum logic [1:0] {
        SET_IDLE,
        SET_WAIT,
        SET_COUNT
    } settle_e;

    function automatic div_t eff_div(div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction

    function automatic word_t pack_word(ctl_t c, logic rdy);
        word_t w;
        w = '0;
        w[EN_BIT] = c.en;
        w[RDY_BIT] = rdy;
        w[DIV_MSB:DIV_LSB] = c.div;
        return w;
    endfunction

endpackage

// File: rtl/sck_rate_regs.sv
module sck_rate_regs
    import sck_rate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  rd,
    input  word_t wdata,
    input  logic  ready,
    output ctl_t  ctl,
    output div_t  wr_div,
    output logic  div_wr,
    output word_t rdata
);

    logic unused_wbits;

    assign wr_div = wdata[DIV_MSB:DIV_LSB];
    assign div_wr = wr && (wr_div != ctl.div);
    assign unused_wbits = ^{wdata[REG_W-1:DIV_MSB+1], wdata[DIV_LSB-1:EN_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            rdata <= '0;
        end else begin
            if (wr) begin
                ctl.en  <= wdata[EN_BIT];
                ctl.div <= wr_div;
            end
            if (rd) begin
                rdata <= pack_word(ctl, ready);
            end
        end
    end

endmodule

// File: rtl/sck_rate_tick.sv
module sck_rate_tick
    import sck_rate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic div_wr,
    input  div_t wr_div,
    input  div_t held_div,
    output logic fire,
    output logic imm_apply,
    output logic bnd_apply,
    output div_t active,
    output logic tick,
    output logic sck
);

    div_t cnt;
    logic pend;

    assign fire      = en && (cnt == div_t'(active - 1'b1));
    assign imm_apply = div_wr && !en;
    assign bnd_apply = pend && (fire || !en);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= div_t'(1);
            pend   <= 1'b0;
            tick   <= 1'b0;
            sck    <= 1'b0;
        end else begin
            if (!en || fire) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end

            if (imm_apply) begin
                active <= eff_div(wr_div);
            end else if (bnd_apply) begin
                active <= eff_div(held_div);
            end

            if (imm_apply) begin
                pend <= 1'b0;
            end else if (div_wr) begin
                pend <= 1'b1;
            end else if (bnd_apply) begin
                pend <= 1'b0;
            end

            tick <= fire;
            if (!en) begin
                sck <= 1'b0;
            end else if (fire) begin
                sck <= ~sck;
            end
        end
    end

endmodule

// File: rtl/sck_rate_settle.sv
module sck_rate_settle
    import sck_rate_pkg::*;
#(
    parameter int SETTLE_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clear,
    input  logic imm,
    input  logic applied,
    input  logic fire,
    output logic ready
);

    localparam int N_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
    localparam logic [N_W-1:0] N_LAST = N_W'(SETTLE_TICKS - 1);

    settle_e         st;
    logic [N_W-1:0]  n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SET_IDLE;
            n     <= '0;
            ready <= 1'b1;
        end else if (clear) begin
            ready <= 1'b0;
            n     <= '0;
            st    <= imm ? SET_COUNT : SET_WAIT;
        end else begin
            case (st)
                SET_WAIT: begin
                    if (!en) begin
                        ready <= 1'b1;
                        st    <= SET_IDLE;
                    end else if (applied) begin
                        n  <= '0;
                        st <= SET_COUNT;
                    end
                end
                SET_COUNT: begin
                    if (!en) begin
                        ready <= 1'b1;
                        st    <= SET_IDLE;
                    end else if (fire) begin
                        if (n == N_LAST) begin
                            ready <= 1'b1;
                            st    <= SET_IDLE;
                        end else begin
                            n <= n + 1'b1;
                        end
                    end
                end
                default: st <= SET_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
    import sck_rate_pkg::*;
#(
    parameter int SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              sck_tick,
    output logic              sck_out
);

    ctl_t ctl;
    div_t wr_div;
    div_t active;
    logic div_wr;
    logic ready;
    logic fire;
    logic imm_apply;
    logic bnd_apply;
    logic run_en;

    assign run_en = ctl.en;

    sck_rate_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .rd     (cfg_rd),
        .wdata  (cfg_wdata),
        .ready  (ready),
        .ctl    (ctl),
        .wr_div (wr_div),
        .div_wr (div_wr),
        .rdata  (cfg_rdata)
    );

    sck_rate_tick u_tick (
        .clk       (clk),
        .rst       (rst),
        .en        (run_en),
        .div_wr    (div_wr),
        .wr_div    (wr_div),
        .held_div  (ctl.div),
        .fire      (fire),
        .imm_apply (imm_apply),
        .bnd_apply (bnd_apply),
        .active    (active),
        .tick      (sck_tick),
        .sck       (sck_out)
    );

    sck_rate_settle #(
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_settle (
        .clk     (clk),
        .rst     (rst),
        .en      (run_en),
        .clear   (div_wr),
        .imm     (imm_apply),
        .applied (bnd_apply),
        .fire    (fire),
        .ready   (ready)
    );

endmodule

// File: rtl/sck_rate_check.sv
module sck_rate_check
    import sck_rate_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic div_wr,
    input logic ready,
    input logic sck_tick,
    input logic sck_out,
    input div_t active
);

    // R3: once the enable is low, no pulse and an idle low clock
    a_r3_off_is_quiet: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!sck_tick && !sck_out));

    // R4: the clock level inverts on every pulse
    a_r4_toggle_on_tick: assert property (@(posedge clk) disable iff (rst)
        sck_tick |-> (sck_out != $past(sck_out)));

    // R4: while running the clock level holds between pulses
    a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
        ($past(run_en) && !sck_tick) |-> $stable(sck_out));

    // R5: back-to-back pulses only with an effective divider of one
    a_r5_min_spacing: assert property (@(posedge clk) disable iff (rst)
        (sck_tick && $past(sck_tick)) |-> ($past(active) == div_t'(1)));

    // R6: a changed divider drops the ready flag
    a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> !ready);

    // R7: a running generator switches rate only on a pulse edge
    a_r7_apply_at_boundary: assert property (@(posedge clk) disable iff (rst)
        ($past(run_en) && (active != $past(active))) |-> sck_tick);

endmodule

bind sck_rate_gen sck_rate_check i_chk (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .div_wr   (div_wr),
    .ready    (ready),
    .sck_tick (sck_tick),
    .sck_out  (sck_out),
    .active   (active)
);

// File: tb/test_sck_rate_gen.sv
`timescale 1ns/1ps
module test_sck_rate_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sck_tick;
    logic        sck_out;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int mon_chk = 0;
    int mon_err = 0;
    int mon_idx = 0;
    int exp_q[$];
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic prev_sck = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sck_rate_gen i_sck_rate_gen (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sck_tick  (sck_tick),
        .sck_out   (sck_out)
    );

    // monitor: every pulse must match the next expected cycle
    always @(negedge clk) begin
        if (mon_on && sck_tick === 1'b1) begin
            mon_chk++;
            if (mon_idx >= exp_q.size()) begin
                mon_err++;
                $display("FAIL R4 unexpected pulse: actual cycle %0d expected none", cyc);
            end else begin
                if (exp_q[mon_idx] != cyc) begin
                    mon_err++;
                    $display("FAIL R4/R7 pulse time: actual %0d expected %0d", cyc, exp_q[mon_idx]);
                end
                mon_idx++;
            end
            mon_chk++;
            if (sck_out === prev_sck) begin
                mon_err++;
                $display("FAIL R4 level toggle: actual %0b expected %0b", sck_out, ~prev_sck);
            end
        end
        prev_sck = sck_out;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic at_cycle(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] data, output int n);
        cfg_wr = 1'b1;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = '0;
        n = cyc;
    endtask

    function automatic logic [31:0] word(input logic [7:0] div, input logic en, input logic b1);
        return {16'h0, div, 6'h0, b1, en};
    endfunction

    task automatic expect_run(input int start, input int d, input int last);
        for (int t = start + d; t <= last; t += d) exp_q.push_back(t);
    endtask

    initial begin
        int n1, n2, z, v, u, dummy;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cfg_rd = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset word", cfg_rdata, 32'h0000_0002);
        check("R1 reset pulse", {31'h0, sck_tick}, 32'h0);
        check("R1 reset level", {31'h0, sck_out}, 32'h0);

        // R5: divider 0 gives a pulse every cycle; unchanged divider keeps ready
        wr(word(8'd0, 1'b1, 1'b0), n1);
        expect_run(n1, 1, n1 + 7);
        at_cycle(n1 + 2);
        check("R6 unchanged divider keeps ready", {31'h0, cfg_rdata[1]}, 32'h1);
        at_cycle(n1 + 6);
        wr(word(8'd0, 1'b0, 1'b0), dummy);
        at_cycle(n1 + 8);
        check("R3 idle level after disable", {31'h0, sck_out}, 32'h0);
        at_cycle(n1 + 14);
        check("R3 still idle", {30'h0, sck_tick, sck_out}, 32'h0);

        // R9: divider 3 written together with enable while off
        at_cycle(n1 + 15);
        wr(word(8'd3, 1'b1, 1'b0), n2);
        exp_q.push_back(n2 + 3);
        exp_q.push_back(n2 + 6);
        exp_q.push_back(n2 + 9);
        exp_q.push_back(n2 + 12);
        exp_q.push_back(n2 + 17);
        exp_q.push_back(n2 + 22);
        exp_q.push_back(n2 + 27);
        exp_q.push_back(n2 + 32);
        at_cycle(n2 + 1);
        check("R6 changed divider clears ready", {31'h0, cfg_rdata[1]}, 32'h0);
        check("R2 divider field", {24'h0, cfg_rdata[15:8]}, 32'h3);
        check("R2 enable bit", {31'h0, cfg_rdata[0]}, 32'h1);
        at_cycle(n2 + 6);
        check("R9 ready low before second pulse", {31'h0, cfg_rdata[1]}, 32'h0);
        at_cycle(n2 + 7);
        check("R9 ready with second pulse", {31'h0, cfg_rdata[1]}, 32'h1);

        // R7/R8: change to 5 mid-period, writing 1 to the ready bit
        at_cycle(n2 + 9);
        wr(word(8'd5, 1'b1, 1'b1), dummy);
        at_cycle(n2 + 11);
        check("R10 write of 1 to ready bit ignored", {31'h0, cfg_rdata[1]}, 32'h0);
        check("R2 new divider field", {24'h0, cfg_rdata[15:8]}, 32'h5);
        at_cycle(n2 + 22);
        check("R8 ready low before second new pulse", {31'h0, cfg_rdata[1]}, 32'h0);
        at_cycle(n2 + 23);
        check("R8 ready with second new pulse", {31'h0, cfg_rdata[1]}, 32'h1);
        wr(32'hFFFF_05FD, dummy);
        at_cycle(n2 + 25);
        check("R2/R10 reserved bits and ready write ignored", cfg_rdata, 32'h0000_0503);

        // R9: switched off while waiting for the boundary
        at_cycle(n2 + 32);
        wr(word(8'd7, 1'b1, 1'b0), dummy);
        wr(word(8'd7, 1'b0, 1'b0), dummy);
        at_cycle(n2 + 35);
        check("R9 ready low while waiting", {31'h0, cfg_rdata[1]}, 32'h0);
        check("R3 level idle after disable", {31'h0, sck_out}, 32'h0);
        at_cycle(n2 + 36);
        check("R9 ready after disable", {31'h0, cfg_rdata[1]}, 32'h1);
        at_cycle(n2 + 39);
        wr(word(8'd7, 1'b1, 1'b0), z);
        expect_run(z, 7, z + 14);
        at_cycle(z + 1);
        check("R6 same divider with enable keeps ready", {31'h0, cfg_rdata[1]}, 32'h1);
        at_cycle(z + 14);
        wr(word(8'd7, 1'b0, 1'b0), dummy);

        // R4/R8: largest divider
        at_cycle(z + 17);
        wr(word(8'd255, 1'b1, 1'b0), v);
        expect_run(v, 255, v + 510);
        at_cycle(v + 510);
        check("R8 ready low at max divider", {31'h0, cfg_rdata[1]}, 32'h0);
        at_cycle(v + 511);
        check("R8 ready at max divider", {31'h0, cfg_rdata[1]}, 32'h1);
        wr(word(8'd255, 1'b0, 1'b0), dummy);

        // R5: changing to 0 runs at the fastest rate
        at_cycle(v + 514);
        wr(word(8'd0, 1'b1, 1'b0), u);
        expect_run(u, 1, u + 6);
        at_cycle(u + 2);
        check("R5 ready low after change to 0", {31'h0, cfg_rdata[1]}, 32'h0);
        at_cycle(u + 3);
        check("R5 ready after two fast pulses", {31'h0, cfg_rdata[1]}, 32'h1);
        at_cycle(u + 5);
        wr(word(8'd0, 1'b0, 1'b0), dummy);
        at_cycle(u + 8);
        check("R3 level idle at end", {31'h0, sck_out}, 32'h0);
        at_cycle(u + 12);
        check("R4 all expected pulses seen", mon_idx, exp_q.size());

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk, n_err + mon_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk + 1, n_err + mon_err + 1);
            $finish;
        end
    end

endmodule